// File: doc/BRIEF.md
# Reorder Buffer with In-Order Retire

This block keeps instructions in program order between decode and commit so that results reach architectural state precisely. Decode allocates one slot per cycle at the tail and receives the slot index back. Execution units later report completion by that index, giving either a result value, an exception mark or (for branches) a misprediction mark. The buffer is a circular store of `DEPTH` slots. Each slot holds the kind of instruction, its PC, its destination (register or not) and the result with its status.

Every cycle the two oldest slots are inspected combinationally. Finished, non-faulting slots at the head drain in order through two register-file write ports. At most two drain per cycle, and the younger one only if the older one also drains. An excepting head slot does not drain. It raises a flush that reports its PC and empties the buffer. A mispredicted branch at the head drains and flushes everything younger in the same cycle.

Top module: `rob_top`

## Requirements
- R1: After reset the buffer is empty: `alloc_ready`=1, `alloc_idx`=0, `ret_cnt`=0, `flush_valid`=0.
- R2: Each accepted allocation returns the current tail index on `alloc_idx`. Successive allocations get consecutive indices modulo `DEPTH`. The tail returns to 0 after any flush.
- R3: With `DEPTH` (16) slots occupied, `alloc_ready` is 0 and an `alloc_valid` request is ignored. The tail index does not move.
- R4: A slot that has not been completed blocks retirement at the head (`ret_cnt`=0), whatever the state of younger slots.
- R5: A completed, non-excepting head slot retires in the cycle after its completion. `ret0_we` is 1 only if the slot has a register destination, with `ret0_addr` = its destination and `ret0_data` = the completed value. A slot without a register destination retires with `ret0_we`=0.
- R6: When the two oldest slots are both finished and clean, both retire in one cycle (`ret_cnt`=2). The older one is on port 0 and the younger on port 1.
- R7: If the oldest slot cannot retire, the second-oldest does not retire in that cycle even when it is finished.
- R8: A completed head slot marked with an exception does not retire. `flush_valid`=1 with `flush_pc` = its PC and `alloc_ready`=0. One cycle later the buffer is empty.
- R9: A head slot of kind branch (kind code 2'b00; ALU is 2'b01, memory 2'b10) completed with the mispredict mark retires (`ret_cnt`=1) while `flush_valid`=1 with `flush_pc` = its PC. All younger slots are discarded, even finished ones.
- R10: When the second-oldest slot is excepting and the oldest is clean, only the oldest retires, with no flush. The flush follows in the next cycle.
- R11: A completion addressed to an index that holds no allocated slot has no effect. That slot, allocated later, stays unfinished.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| alloc_valid | input | 1 | Decode requests a slot |
| alloc_kind | input | 2 | Instruction kind: 00 branch, 01 ALU, 10 memory |
| alloc_pc | input | 32 | Instruction PC |
| alloc_dst_is_reg | input | 1 | Instruction writes an architectural register |
| alloc_dst | input | 5 | Destination register number |
| alloc_ready | output | 1 | A slot can be accepted this cycle |
| alloc_idx | output | 4 | Index given to the allocation (tail) |
| cmpl_valid | input | 1 | Completion report |
| cmpl_idx | input | 4 | Slot being completed |
| cmpl_value | input | 32 | Result value |
| cmpl_exc | input | 1 | Completion carries an exception |
| cmpl_mispred | input | 1 | Branch was mispredicted |
| ret_cnt | output | 2 | Slots retiring this cycle (0..2) |
| ret0_we | output | 1 | Register write for the oldest retiring slot |
| ret0_addr | output | 5 | Its destination register |
| ret0_data | output | 32 | Its value |
| ret1_we | output | 1 | Register write for the second retiring slot |
| ret1_addr | output | 5 | Its destination register |
| ret1_data | output | 32 | Its value |
| flush_valid | output | 1 | Younger work is discarded this cycle |
| flush_pc | output | 32 | PC of the head slot causing the flush |

## Verification
Slot state is registered, while the retire ports, the flush and `alloc_ready` are combinational views of it. A completion presented in one cycle therefore shows on the retire or flush outputs in the very next cycle. The buffer is empty one cycle after a flush, and `alloc_idx` moves one cycle after an accepted allocation. The bench drives inputs on the falling edge and samples outputs 3 ns later, just before the rising edge that acts on them. Each directed check is placed in the cycle right after the stimulus it depends on. Retirements are matched in order against a scoreboard queue filled when each completion is issued, so any unexpected, missing or reordered retirement is reported.

// File: rtl/rob_pkg.sv
// Shared widths, kind codes and slot layout for the reorder buffer.
package rob_pkg;
    localparam int ROB_XLEN   = 32;  // result width
    localparam int ROB_PC_W   = 32;  // PC width
    localparam int ROB_AREG_W = 5;   // architectural register number width

    typedef enum logic [1:0] {
        KIND_BRANCH = 2'b00,
        KIND_ALU    = 2'b01,
        KIND_MEM    = 2'b10
    } kind_e;

    typedef struct packed {
        kind_e                 kind;
        logic [ROB_PC_W-1:0]   pc;
        logic                  dst_is_reg;
        logic [ROB_AREG_W-1:0] dst;
        logic [ROB_XLEN-1:0]   value;
        logic                  done;
        logic                  exc;
        logic                  mispred;
    } slot_t;
endpackage

// File: rtl/rob_ptr_ctrl.sv
// Head/tail/occupancy bookkeeping of the circular buffer.
// Assumes DEPTH is a power of two so pointers wrap by overflow,
// and that ret_cnt never exceeds the occupancy.
module rob_ptr_ctrl #(
    parameter int DEPTH = 16,
    localparam int IDX_W = $clog2(DEPTH),
    localparam int CNT_W = IDX_W + 1
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             alloc_fire,
    input  logic [1:0]       ret_cnt,
    input  logic             flush,
    output logic [IDX_W-1:0] head,
    output logic [IDX_W-1:0] tail,
    output logic [CNT_W-1:0] count,
    output logic             full
);
    // Advance pointers on allocate/retire; a flush empties everything.
    always_ff @(posedge clk) begin
        if (!rst_n || flush) begin
            head  <= '0;
            tail  <= '0;
            count <= '0;
        end else begin
            head  <= head + IDX_W'(ret_cnt);
            tail  <= tail + IDX_W'(alloc_fire);
            count <= count + CNT_W'(alloc_fire) - CNT_W'(ret_cnt);
        end
    end

    // Full when every slot is occupied.
    always_comb full = (count == CNT_W'(DEPTH));
endmodule

// File: rtl/rob_slot_store.sv
// Per-slot storage with a valid bit. Writes a new slot at the tail,
// merges completions into valid slots only, clears retired slots and
// drops all slots on flush. Presents the two oldest slots.
module rob_slot_store
    import rob_pkg::*;
#(
    parameter int DEPTH = 16,
    localparam int IDX_W = $clog2(DEPTH)
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                alloc_fire,
    input  logic [IDX_W-1:0]    tail,
    input  slot_t               alloc_slot,
    input  logic                cmpl_valid,
    input  logic [IDX_W-1:0]    cmpl_idx,
    input  logic [ROB_XLEN-1:0] cmpl_value,
    input  logic                cmpl_exc,
    input  logic                cmpl_mispred,
    input  logic [1:0]          ret_cnt,
    input  logic [IDX_W-1:0]    head,
    input  logic                flush,
    output slot_t               old0,
    output logic                old0_v,
    output slot_t               old1,
    output logic                old1_v
);
    slot_t            slots [DEPTH];
    logic [DEPTH-1:0] live;
    logic [IDX_W-1:0] head_nxt;

    always_comb head_nxt = head + IDX_W'(1);

    for (genvar i = 0; i < DEPTH; i++) begin : g_slot
        logic ret_here;
        // This slot leaves the buffer through retirement this cycle.
        always_comb ret_here = (ret_cnt != 2'd0 && head == IDX_W'(i)) ||
                               (ret_cnt == 2'd2 && head_nxt == IDX_W'(i));

        // Slot state update: reset/flush, retire, allocate, complete.
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                live[i]  <= 1'b0;
                slots[i] <= '0;
            end else if (flush) begin
                live[i] <= 1'b0;
            end else if (alloc_fire && tail == IDX_W'(i)) begin
                live[i]  <= 1'b1;
                slots[i] <= alloc_slot;
            end else if (ret_here) begin
                live[i] <= 1'b0;
            end else if (cmpl_valid && cmpl_idx == IDX_W'(i) && live[i]) begin
                slots[i].value   <= cmpl_value;
                slots[i].done    <= 1'b1;
                slots[i].exc     <= cmpl_exc;
                slots[i].mispred <= cmpl_mispred;
            end
        end
    end

    // Read out the oldest two slots.
    always_comb begin
        old0   = slots[head];
        old0_v = live[head];
        old1   = slots[head_nxt];
        old1_v = live[head_nxt];
    end
endmodule

// File: rtl/rob_retire_sel.sv
// Combinational commit decision over the two oldest slots: how many
// retire, the register write ports, and whether a flush is raised.
// Assumes the slot valid bits are consistent with program order.
module rob_retire_sel
    import rob_pkg::*;
(
    input  slot_t                 old0,
    input  logic                  old0_v,
    input  slot_t                 old1,
    input  logic                  old1_v,
    output logic [1:0]            ret_cnt,
    output logic                  ret0_we,
    output logic [ROB_AREG_W-1:0] ret0_addr,
    output logic [ROB_XLEN-1:0]   ret0_data,
    output logic                  ret1_we,
    output logic [ROB_AREG_W-1:0] ret1_addr,
    output logic [ROB_XLEN-1:0]   ret1_data,
    output logic                  flush,
    output logic [ROB_PC_W-1:0]   flush_pc
);
    logic go0, go1, redirect0, fault0, clean1;

    // Decide which of the two oldest slots commit and whether to flush.
    always_comb begin
        go0       = old0_v && old0.done && !old0.exc;
        redirect0 = go0 && old0.kind == KIND_BRANCH && old0.mispred;
        fault0    = old0_v && old0.done && old0.exc;
        clean1    = old1_v && old1.done && !old1.exc &&
                    !(old1.kind == KIND_BRANCH && old1.mispred);
        go1       = go0 && !redirect0 && clean1;
        ret_cnt   = go1 ? 2'd2 : (go0 ? 2'd1 : 2'd0);
        flush     = fault0 || redirect0;
        flush_pc  = old0.pc;
    end

    // Drive the two architectural register write ports.
    always_comb begin
        ret0_we   = go0 && old0.dst_is_reg;
        ret0_addr = old0.dst;
        ret0_data = old0.value;
        ret1_we   = go1 && old1.dst_is_reg;
        ret1_addr = old1.dst;
        ret1_data = old1.value;
    end
endmodule

// File: rtl/rob_top.sv
// Reorder buffer top: in-order allocation, completion by index,
// in-order retirement of up to two slots per cycle, and a flush on
// a faulting or mispredicted head slot. DEPTH must be a power of two.
module rob_top
    import rob_pkg::*;
#(
    parameter int DEPTH = 16,
    localparam int IDX_W = $clog2(DEPTH),
    localparam int CNT_W = IDX_W + 1
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  alloc_valid,
    input  logic [1:0]            alloc_kind,
    input  logic [ROB_PC_W-1:0]   alloc_pc,
    input  logic                  alloc_dst_is_reg,
    input  logic [ROB_AREG_W-1:0] alloc_dst,
    output logic                  alloc_ready,
    output logic [IDX_W-1:0]      alloc_idx,
    input  logic                  cmpl_valid,
    input  logic [IDX_W-1:0]      cmpl_idx,
    input  logic [ROB_XLEN-1:0]   cmpl_value,
    input  logic                  cmpl_exc,
    input  logic                  cmpl_mispred,
    output logic [1:0]            ret_cnt,
    output logic                  ret0_we,
    output logic [ROB_AREG_W-1:0] ret0_addr,
    output logic [ROB_XLEN-1:0]   ret0_data,
    output logic                  ret1_we,
    output logic [ROB_AREG_W-1:0] ret1_addr,
    output logic [ROB_XLEN-1:0]   ret1_data,
    output logic                  flush_valid,
    output logic [ROB_PC_W-1:0]   flush_pc
);
    logic             alloc_fire, full;
    logic [IDX_W-1:0] head, tail;
    logic [CNT_W-1:0] count;
    slot_t            new_slot, old0, old1;
    logic             old0_v, old1_v;

    // Accept a new slot only when space exists and no flush is active.
    always_comb begin
        alloc_ready = !full && !flush_valid;
        alloc_fire  = alloc_valid && alloc_ready;
        alloc_idx   = tail;
    end

    // Build the fresh slot image written at the tail.
    always_comb begin
        new_slot            = '0;
        new_slot.kind       = kind_e'(alloc_kind);
        new_slot.pc         = alloc_pc;
        new_slot.dst_is_reg = alloc_dst_is_reg;
        new_slot.dst        = alloc_dst;
    end

    rob_ptr_ctrl #(.DEPTH(DEPTH)) u_ptr (
        .clk        (clk),
        .rst_n      (rst_n),
        .alloc_fire (alloc_fire),
        .ret_cnt    (ret_cnt),
        .flush      (flush_valid),
        .head       (head),
        .tail       (tail),
        .count      (count),
        .full       (full)
    );

    rob_slot_store #(.DEPTH(DEPTH)) u_store (
        .clk          (clk),
        .rst_n        (rst_n),
        .alloc_fire   (alloc_fire),
        .tail         (tail),
        .alloc_slot   (new_slot),
        .cmpl_valid   (cmpl_valid),
        .cmpl_idx     (cmpl_idx),
        .cmpl_value   (cmpl_value),
        .cmpl_exc     (cmpl_exc),
        .cmpl_mispred (cmpl_mispred),
        .ret_cnt      (ret_cnt),
        .head         (head),
        .flush        (flush_valid),
        .old0         (old0),
        .old0_v       (old0_v),
        .old1         (old1),
        .old1_v       (old1_v)
    );

    rob_retire_sel u_sel (
        .old0      (old0),
        .old0_v    (old0_v),
        .old1      (old1),
        .old1_v    (old1_v),
        .ret_cnt   (ret_cnt),
        .ret0_we   (ret0_we),
        .ret0_addr (ret0_addr),
        .ret0_data (ret0_data),
        .ret1_we   (ret1_we),
        .ret1_addr (ret1_addr),
        .ret1_data (ret1_data),
        .flush     (flush_valid),
        .flush_pc  (flush_pc)
    );
endmodule

// File: rtl/rob_checker.sv
// Temporal properties of the reorder buffer, bound to rob_top.
module rob_checker #(
    parameter int DEPTH = 16,
    localparam int CNT_W = $clog2(DEPTH) + 1
) (
    input logic             clk,
    input logic             rst_n,
    input logic             alloc_valid,
    input logic             alloc_ready,
    input logic [1:0]       ret_cnt,
    input logic             ret0_we,
    input logic             ret1_we,
    input logic             flush_valid,
    input logic [CNT_W-1:0] count
);
    logic seen;
    // Marks that at least one cycle has passed out of reset.
    always_ff @(posedge clk) seen <= rst_n;

    p_bound_r3: assert property (@(posedge clk) disable iff (!rst_n)
        count <= CNT_W'(DEPTH));

    p_full_stall_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (count == CNT_W'(DEPTH)) |-> !alloc_ready);

    p_flush_empties_r8: assert property (@(posedge clk) disable iff (!rst_n)
        flush_valid |=> (count == '0));

    p_pair_order_r6: assert property (@(posedge clk) disable iff (!rst_n)
        ret1_we |-> (ret_cnt == 2'd2 && !$isunknown(ret0_we)));

    p_retire_in_range_r5: assert property (@(posedge clk) disable iff (!rst_n)
        CNT_W'(ret_cnt) <= count);

    p_occupancy_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (seen && !$past(flush_valid)) |->
        count == $past(count) + CNT_W'($past(alloc_valid && alloc_ready))
                 - CNT_W'($past(ret_cnt)));
endmodule

bind rob_top rob_checker #(.DEPTH(DEPTH)) u_rob_checker (
    .clk         (clk),
    .rst_n       (rst_n),
    .alloc_valid (alloc_valid),
    .alloc_ready (alloc_ready),
    .ret_cnt     (ret_cnt),
    .ret0_we     (ret0_we),
    .ret1_we     (ret1_we),
    .flush_valid (flush_valid),
    .count       (count)
);

// File: tb/tb_rob_top.sv
// Scoreboard bench: tests push expected retirements into a queue,
// a monitor pops and compares them as the ports retire slots.
module tb_rob_top;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        alloc_valid = 1'b0;
    logic [1:0]  alloc_kind = 2'b01;
    logic [31:0] alloc_pc = '0;
    logic        alloc_dst_is_reg = 1'b0;
    logic [4:0]  alloc_dst = '0;
    logic        alloc_ready;
    logic [3:0]  alloc_idx;
    logic        cmpl_valid = 1'b0;
    logic [3:0]  cmpl_idx = '0;
    logic [31:0] cmpl_value = '0;
    logic        cmpl_exc = 1'b0;
    logic        cmpl_mispred = 1'b0;
    logic [1:0]  ret_cnt;
    logic        ret0_we, ret1_we;
    logic [4:0]  ret0_addr, ret1_addr;
    logic [31:0] ret0_data, ret1_data;
    logic        flush_valid;
    logic [31:0] flush_pc;

    int total = 0;
    int bad = 0;
    bit finished = 1'b0;

    typedef struct packed {
        logic        we;
        logic [4:0]  addr;
        logic [31:0] data;
    } exp_t;
    exp_t exp_q[$];

    always #4 clk = ~clk;  // 125 MHz

    rob_top dut (
        .clk(clk), .rst_n(rst_n),
        .alloc_valid(alloc_valid), .alloc_kind(alloc_kind), .alloc_pc(alloc_pc),
        .alloc_dst_is_reg(alloc_dst_is_reg), .alloc_dst(alloc_dst),
        .alloc_ready(alloc_ready), .alloc_idx(alloc_idx),
        .cmpl_valid(cmpl_valid), .cmpl_idx(cmpl_idx), .cmpl_value(cmpl_value),
        .cmpl_exc(cmpl_exc), .cmpl_mispred(cmpl_mispred),
        .ret_cnt(ret_cnt),
        .ret0_we(ret0_we), .ret0_addr(ret0_addr), .ret0_data(ret0_data),
        .ret1_we(ret1_we), .ret1_addr(ret1_addr), .ret1_data(ret1_data),
        .flush_valid(flush_valid), .flush_pc(flush_pc)
    );

    task automatic chk(string req, logic [63:0] act, logic [63:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic clr();
        alloc_valid  = 1'b0;
        cmpl_valid   = 1'b0;
        cmpl_exc     = 1'b0;
        cmpl_mispred = 1'b0;
    endtask

    task automatic push_exp(logic we, logic [4:0] addr, logic [31:0] data);
        exp_q.push_back(we ? {we, addr, data} : '0);
    endtask

    task automatic alloc(logic [1:0] kind, logic [31:0] pc, logic isreg,
                         logic [4:0] dst, logic [3:0] exp_idx);
        @(negedge clk);
        clr();
        alloc_valid = 1'b1; alloc_kind = kind; alloc_pc = pc;
        alloc_dst_is_reg = isreg; alloc_dst = dst;
        #3;
        chk("R2 alloc_idx", 64'(alloc_idx), 64'(exp_idx));
        chk("R2 alloc_ready", 64'(alloc_ready), 64'd1);
    endtask

    task automatic cmpl(logic [3:0] idx, logic [31:0] val, logic exc, logic mis);
        @(negedge clk);
        clr();
        cmpl_valid = 1'b1; cmpl_idx = idx; cmpl_value = val;
        cmpl_exc = exc; cmpl_mispred = mis;
    endtask

    task automatic idle_chk(string req, logic [1:0] exp_cnt, logic exp_fl);
        @(negedge clk);
        clr();
        #3;
        chk({req, " ret_cnt"}, 64'(ret_cnt), 64'(exp_cnt));
        chk({req, " flush_valid"}, 64'(flush_valid), 64'(exp_fl));
    endtask

    // Monitor: compare each retiring slot against the scoreboard head.
    always @(negedge clk) begin
        #3;
        if (rst_n && !finished) begin
            if (ret_cnt >= 2'd1) begin
                if (exp_q.size() == 0) chk("R5 unexpected retire port0", 64'd1, 64'd0);
                else chk("R5 port0 retire", ret0_we ? 64'({ret0_we, ret0_addr, ret0_data}) : 64'd0,
                         64'(exp_q.pop_front()));
            end
            if (ret_cnt == 2'd2) begin
                if (exp_q.size() == 0) chk("R6 unexpected retire port1", 64'd1, 64'd0);
                else chk("R6 port1 retire", ret1_we ? 64'({ret1_we, ret1_addr, ret1_data}) : 64'd0,
                         64'(exp_q.pop_front()));
            end
        end
    end

    // Watchdog: a hung run is a failed check.
    initial begin
        repeat (20000) @(posedge clk);
        if (!finished) begin
            finished = 1'b1;
            total++; bad++;
            $display("FAIL watchdog actual=running expected=done");
            $display("  test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        #3;
        // R1 reset state
        chk("R1 alloc_ready", 64'(alloc_ready), 64'd1);
        chk("R1 alloc_idx", 64'(alloc_idx), 64'd0);
        chk("R1 ret_cnt", 64'(ret_cnt), 64'd0);
        chk("R1 flush_valid", 64'(flush_valid), 64'd0);

        // R2/R4/R7/R6: three ALU slots completed out of order
        alloc(2'b01, 32'h100, 1'b1, 5'd1, 4'd0);
        alloc(2'b01, 32'h104, 1'b1, 5'd2, 4'd1);
        alloc(2'b01, 32'h108, 1'b1, 5'd3, 4'd2);
        idle_chk("R4 unfinished head", 2'd0, 1'b0);
        cmpl(4'd2, 32'hA2, 1'b0, 1'b0);
        idle_chk("R4 head blocks younger", 2'd0, 1'b0);
        push_exp(1'b1, 5'd1, 32'hA0);
        cmpl(4'd0, 32'hA0, 1'b0, 1'b0);
        idle_chk("R5 single retire", 2'd1, 1'b0);
        idle_chk("R7 second waits for first", 2'd0, 1'b0);
        push_exp(1'b1, 5'd2, 32'hA1);
        push_exp(1'b1, 5'd3, 32'hA2);
        cmpl(4'd1, 32'hA1, 1'b0, 1'b0);
        idle_chk("R6 dual retire", 2'd2, 1'b0);

        // R5: memory slot without register destination
        alloc(2'b10, 32'h200, 1'b0, 5'd4, 4'd3);
        push_exp(1'b0, 5'd0, 32'd0);
        cmpl(4'd3, 32'h55, 1'b0, 1'b0);
        idle_chk("R5 no-register retire", 2'd1, 1'b0);
        chk("R5 ret0_we low", 64'(ret0_we), 64'd0);

        // R8: exception at head
        alloc(2'b01, 32'h400, 1'b1, 5'd5, 4'd4);
        alloc(2'b01, 32'h404, 1'b1, 5'd6, 4'd5);
        cmpl(4'd5, 32'h66, 1'b0, 1'b0);
        cmpl(4'd4, 32'h0, 1'b1, 1'b0);
        idle_chk("R8 exception head", 2'd0, 1'b1);
        chk("R8 flush_pc", 64'(flush_pc), 64'h400);
        chk("R8 alloc_ready low", 64'(alloc_ready), 64'd0);
        idle_chk("R8 after flush", 2'd0, 1'b0);
        chk("R8 empty tail", 64'(alloc_idx), 64'd0);

        // R9: mispredicted branch at head
        alloc(2'b00, 32'h500, 1'b0, 5'd0, 4'd0);
        alloc(2'b01, 32'h504, 1'b1, 5'd7, 4'd1);
        cmpl(4'd1, 32'h77, 1'b0, 1'b0);
        push_exp(1'b0, 5'd0, 32'd0);
        cmpl(4'd0, 32'h0, 1'b0, 1'b1);
        idle_chk("R9 mispredict head", 2'd1, 1'b1);
        chk("R9 flush_pc", 64'(flush_pc), 64'h500);
        idle_chk("R9 younger discarded", 2'd0, 1'b0);
        chk("R9 empty tail", 64'(alloc_idx), 64'd0);

        // R10: excepting second slot behind a clean head
        alloc(2'b01, 32'h600, 1'b1, 5'd8, 4'd0);
        alloc(2'b01, 32'h604, 1'b1, 5'd9, 4'd1);
        cmpl(4'd1, 32'h0, 1'b1, 1'b0);
        push_exp(1'b1, 5'd8, 32'h88);
        cmpl(4'd0, 32'h88, 1'b0, 1'b0);
        idle_chk("R10 clean head only", 2'd1, 1'b0);
        idle_chk("R10 flush next cycle", 2'd0, 1'b1);
        chk("R10 flush_pc", 64'(flush_pc), 64'h604);
        idle_chk("R10 drained", 2'd0, 1'b0);

        // R11: completion to an unallocated slot is dropped
        cmpl(4'd0, 32'h99, 1'b0, 1'b0);
        alloc(2'b01, 32'h700, 1'b1, 5'd10, 4'd0);
        alloc(2'b01, 32'h704, 1'b1, 5'd11, 4'd1);
        alloc(2'b01, 32'h708, 1'b1, 5'd12, 4'd2);
        alloc(2'b01, 32'h70C, 1'b1, 5'd13, 4'd3);
        idle_chk("R11 stale completion ignored", 2'd0, 1'b0);
        for (int i = 0; i < 4; i++) begin
            push_exp(1'b1, 5'(10 + i), 32'(32'hB0 + i));
            cmpl(4'(i), 32'(32'hB0 + i), 1'b0, 1'b0);
        end
        idle_chk("R5 drain tail", 2'd1, 1'b0);
        idle_chk("R5 drained", 2'd0, 1'b0);

        // R3: fill all 16 slots, then request one more
        for (int i = 0; i < 16; i++)
            alloc(2'b01, 32'(32'h1000 + 4 * i), 1'b1, 5'(i + 1), 4'(4 + i));
        @(negedge clk);
        clr();
        alloc_valid = 1'b1; alloc_pc = 32'hDEAD; alloc_dst = 5'd31;
        #3;
        chk("R3 full stall", 64'(alloc_ready), 64'd0);
        chk("R3 tail held", 64'(alloc_idx), 64'd4);
        idle_chk("R3 ignored request", 2'd0, 1'b0);
        chk("R3 tail unchanged", 64'(alloc_idx), 64'd4);
        cmpl(4'd5, 32'h2222, 1'b0, 1'b0);
        idle_chk("R7 finished second held", 2'd0, 1'b0);
        push_exp(1'b1, 5'd1, 32'h1111);
        push_exp(1'b1, 5'd2, 32'h2222);
        cmpl(4'd4, 32'h1111, 1'b0, 1'b0);
        idle_chk("R6 dual retire when full", 2'd2, 1'b0);
        alloc(2'b01, 32'h2000, 1'b1, 5'd20, 4'd4);
        cmpl(4'd6, 32'h0, 1'b1, 1'b0);
        idle_chk("R8 flush from full", 2'd0, 1'b1);
        chk("R8 flush_pc full", 64'(flush_pc), 64'h1008);
        idle_chk("R8 emptied", 2'd0, 1'b0);

        @(negedge clk);
        chk("scoreboard empty", 64'(exp_q.size()), 64'd0);
        finished = 1'b1;
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule